// File: doc/BRIEF.md
# AES-128 Iterative Decryption Datapath

This block turns one 128-bit ciphertext into its 128-bit plaintext using the inverse AES-128 cipher. It performs one inverse round per clock. A single-cycle start strobe captures the ciphertext and adds round key 10 to it in the same edge. The datapath then runs ten further rounds. Each round applies the inverse row rotation, the inverse byte substitution and the round-key addition. Every round except the last then applies the inverse column mixing. The last round is the one that omits the mixing step.

The round keys are not stored inside the block. It drives a key index and reads a 128-bit round key back combinationally on the same cycle. It shares this read interface with the matching encryption engine and walks the key schedule from index 10 down to index 0. The plaintext and the done flag are registered. Both hold their values until the next accepted start.

Byte order: byte i of any 128-bit value occupies bits [127-8i : 120-8i]. The state is laid out column by column, so byte i sits in row i mod 4 and column i div 4.

Top module: `aes128_decrypt`

## Requirements
- R1: During reset and after it, `busy`, `done` and `pt_out` are 0 and `rk_addr` is 10.
- R2: While `busy` is low, `rk_addr` stays at 10. A `start` seen at a rising edge captures `ct_in` XOR `rk_data` and sets `busy`.
- R3: On the ten cycles after an accepted start, `rk_addr` presents 9, 8, … 0 on consecutive cycles, one round per cycle.
- R4: `done` rises and `busy` falls exactly 10 rising edges after the edge that accepted `start`. `busy` stays high during all ten round cycles.
- R5: Rounds that use keys 9 to 1 apply inverse column mixing after the key addition. The round that uses key 0 does not apply it.
- R6: The inverse row step rotates row r of the state right by r byte positions.
- R7: Inverse column mixing multiplies each column by the circulant matrix with first row {0E,0B,0D,09} over GF(2^8), reduced by 0x11B.
- R8: Inverse substitution maps each byte through the inverse of the AES S-box. That S-box is the multiplicative inverse in GF(2^8) followed by the affine map with constant 0x63. The result for the standard 128-bit test vector (key 000102…0F, ciphertext 69C4E0D86A7B0430D8CDB78070B4C55A) is 00112233445566778899AABBCCDDEEFF.
- R9: Decrypting the AES-128 encryption of any plaintext under any key returns that plaintext.
- R10: A `start` asserted while `busy` is high is ignored. The running result and its timing are unchanged.
- R11: After completion, `done` and `pt_out` hold until the next accepted `start`. `done` is 0 on the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only while idle |
| ct_in | input | 128 | Ciphertext, sampled with an accepted start |
| rk_addr | output | AW (4) | Round-key index requested this cycle |
| rk_data | input | 128 | Round key for `rk_addr`, valid in the same cycle |
| pt_out | output | 128 | Recovered plaintext, registered |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | Plaintext valid, held until the next start |

## Verification
The accepting edge loads the state, so `busy` and `rk_addr` = 9 are visible right after that edge. Each following edge completes one round, and the index drops by one per edge. The plaintext and `done` appear after the tenth edge that follows the accepting one. The bench drives inputs on falling edges. It checks the key index on each of the ten falling edges after the start edge, then checks `done`, `busy` and `pt_out` on the falling edge after the tenth round edge. The hold and ignored-start checks sample on falling edges too, at points counted from the same start edge.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
  localparam int BLK_W  = 128;
  localparam int NBYTES = BLK_W / 8;
  localparam int NROUND = 10;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // a^254 gives the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  // inverse affine map, then field inverse
  function automatic logic [7:0] inv_sub(input logic [7:0] b);
    logic [7:0] t;
    t = rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
    return ginv(t);
  endfunction
endpackage

// File: rtl/aes_inv_sub_shift.sv
module aes_inv_sub_shift
  import aes_dec_pkg::*;
#(
  parameter int W = BLK_W
) (
  input  logic [W-1:0] s_in,
  output logic [W-1:0] s_out
);
  localparam int NB = W / 8;
  localparam int NC = NB / 4;

  for (genvar c = 0; c < NC; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC = 4 * ((c - r + NC) % NC) + r;
      localparam int DST = 4 * c + r;
      assign s_out[W-1-8*DST -: 8] = inv_sub(s_in[W-1-8*SRC -: 8]);
    end
  end
endmodule

// File: rtl/aes_inv_mix.sv
module aes_inv_mix
  import aes_dec_pkg::*;
#(
  parameter int W = BLK_W
) (
  input  logic [W-1:0] s_in,
  output logic [W-1:0] s_out
);
  localparam int NC = W / 32;

  for (genvar c = 0; c < NC; c++) begin : g_col
    logic [7:0] a [4];
    for (genvar r = 0; r < 4; r++) begin : g_in
      assign a[r] = s_in[W-1-8*(4*c+r) -: 8];
    end
    for (genvar r = 0; r < 4; r++) begin : g_out
      assign s_out[W-1-8*(4*c+r) -: 8] =
          gmul(a[r], 8'h0E) ^ gmul(a[(r+1)%4], 8'h0B) ^
          gmul(a[(r+2)%4], 8'h0D) ^ gmul(a[(r+3)%4], 8'h09);
    end
  end
endmodule

// File: rtl/aes_dec_ctrl.sv
module aes_dec_ctrl #(
  parameter int NR = 10,
  parameter int AW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          last,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] rnd
);
  localparam logic [AW-1:0] TOP_KEY = AW'(NR);
  localparam logic [AW-1:0] FIRST_RND = AW'(NR - 1);

  assign load = start && !busy;
  assign last = busy && (rnd == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      rnd  <= TOP_KEY;
    end else if (load) begin
      busy <= 1'b1;
      done <= 1'b0;
      rnd  <= FIRST_RND;
    end else if (last) begin
      busy <= 1'b0;
      done <= 1'b1;
      rnd  <= TOP_KEY;
    end else if (busy) begin
      rnd  <= rnd - AW'(1);
    end
  end

  // R2
  idle_key_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> rnd == TOP_KEY);
  // R3
  key_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy && rnd != '0 |=> busy && rnd == $past(rnd) - AW'(1));
  // R4
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    busy && rnd == '0 |=> done && !busy);
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && rnd != '0 && start |=> busy && rnd == $past(rnd) - AW'(1));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);
endmodule

// File: rtl/aes128_decrypt.sv
module aes128_decrypt
  import aes_dec_pkg::*;
#(
  parameter int W  = BLK_W,
  parameter int NR = NROUND,
  parameter int AW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  ct_in,
  output logic [AW-1:0] rk_addr,
  input  logic [W-1:0]  rk_data,
  output logic [W-1:0]  pt_out,
  output logic          busy,
  output logic          done
);
  logic         load, last;
  logic [W-1:0] st, sub_q, keyed, mixed;

  aes_dec_ctrl #(.NR(NR), .AW(AW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .load(load), .last(last),
    .busy(busy), .done(done), .rnd(rk_addr)
  );

  aes_inv_sub_shift #(.W(W)) subsh_i (.s_in(st), .s_out(sub_q));
  assign keyed = sub_q ^ rk_data;
  aes_inv_mix #(.W(W)) mix_i (.s_in(keyed), .s_out(mixed));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      pt_out <= '0;
    end else if (load) begin
      st <= ct_in ^ rk_data;
    end else if (busy) begin
      st <= last ? keyed : mixed;
      if (last) pt_out <= keyed;
    end
  end

  // R11
  pt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> $stable(pt_out));
  // R4
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !done);
endmodule

// File: tb/aes128_decrypt_tb_top.sv
module aes128_decrypt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [127:0] ct_in;
  logic [AW-1:0] rk_addr;
  logic [127:0] rk_data;
  logic [127:0] pt_out;
  logic         busy, done;

  logic [127:0] tb_rk [0:15];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes128_decrypt dut_i (
    .clk(clk), .rst(rst), .start(start), .ct_in(ct_in),
    .rk_addr(rk_addr), .rk_data(rk_data), .pt_out(pt_out),
    .busy(busy), .done(done)
  );

  assign rk_data = tb_rk[rk_addr];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog expired: cycles %0d expected below 60000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- reference AES-128 encryption, written from the standard ----
  function automatic logic [7:0] f_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] f_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= p;
      p = f_xt(p);
    end
    return r;
  endfunction

  function automatic logic [7:0] f_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00, y;
    for (int k = 1; k < 256; k++)
      if (f_mul(x, 8'(k)) == 8'h01) inv = 8'(k);
    y = inv;
    for (int s = 1; s < 5; s++) y ^= (inv << s) | (inv >> (8 - s));
    return y ^ 8'h63;
  endfunction

  logic [7:0] sb_tab [256];

  function automatic logic [7:0] bt(input logic [127:0] v, input int i);
    return v[127-8*i -: 8];
  endfunction

  function automatic void expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb_tab[t[31:24]], sb_tab[t[23:16]], sb_tab[t[15:8]], sb_tab[t[7:0]]};
        t ^= {rc, 24'h0};
        rc = f_xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) tb_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction

  function automatic logic [127:0] encrypt(input logic [127:0] pt);
    logic [127:0] s, o;
    logic [7:0] a0, a1, a2, a3;
    s = pt ^ tb_rk[0];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          o[127-8*(4*c+r) -: 8] = sb_tab[bt(s, 4*((c+r)%4)+r)];
      s = o;
      if (rd != 10)
        for (int c = 0; c < 4; c++) begin
          a0 = bt(s, 4*c); a1 = bt(s, 4*c+1); a2 = bt(s, 4*c+2); a3 = bt(s, 4*c+3);
          o[127-32*c -: 32] = {f_xt(a0) ^ f_xt(a1) ^ a1 ^ a2 ^ a3,
                               a0 ^ f_xt(a1) ^ f_xt(a2) ^ a2 ^ a3,
                               a0 ^ a1 ^ f_xt(a2) ^ f_xt(a3) ^ a3,
                               f_xt(a0) ^ a0 ^ a1 ^ a2 ^ f_xt(a3)};
        end
      s = o ^ tb_rk[rd];
    end
    return s;
  endfunction

  // one decryption run; optionally pulses start again in the middle (R10)
  task automatic run(input logic [127:0] ct, input logic [127:0] exp_pt,
                     input bit poke, input string tag);
    @(negedge clk);
    start = 1'b1; ct_in = ct;
    @(negedge clk);
    start = 1'b0; ct_in = ~ct;
    // R11: done drops on the cycle after an accepted start
    chk("R11 done cleared by start", 128'(done), 128'd0);
    for (int i = 9; i >= 0; i--) begin
      chk("R3 key index sequence", 128'(rk_addr), 128'(i));
      chk("R4 busy during rounds", 128'(busy), 128'd1);
      if (poke && i == 5) start = 1'b1;   // R10 start while busy
      @(negedge clk);
      start = 1'b0;
    end
    chk("R4 done after ten rounds", 128'(done), 128'd1);
    chk("R4 busy low after rounds", 128'(busy), 128'd0);
    chk("R2 idle key index 10", 128'(rk_addr), 128'd10);
    chk(tag, pt_out, exp_pt);
  endtask

  initial begin
    logic [127:0] key, pt, ct;
    for (int k = 0; k < 256; k++) sb_tab[k] = f_sbox(8'(k));
    for (int r = 0; r < 16; r++) tb_rk[r] = '0;
    rst = 1'b1; start = 1'b0; ct_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 128'(busy), 128'd0);
    chk("R1 done", 128'(done), 128'd0);
    chk("R1 pt_out", pt_out, 128'd0);
    chk("R1 rk_addr", 128'(rk_addr), 128'd10);
    rst = 1'b0;
    @(negedge clk);

    // R8 known-answer vector; also pins R5, R6, R7
    key = 128'h000102030405060708090a0b0c0d0e0f;
    expand(key);
    chk("R8 reference encryptor", encrypt(128'h00112233445566778899aabbccddeeff),
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff,
        1'b0, "R8 R5 R6 R7 known answer");

    // R11 hold after completion
    repeat (4) @(negedge clk);
    chk("R11 done held", 128'(done), 128'd1);
    chk("R11 pt held", pt_out, 128'h00112233445566778899aabbccddeeff);

    // corner cases: all-zero and all-one key/plaintext
    expand('0);
    run(encrypt('0), '0, 1'b0, "R9 zero key zero text");
    expand('1);
    run(encrypt('1), '1, 1'b0, "R9 ones key ones text");

    // R10: start while busy ignored
    expand(key);
    pt = 128'hdeadbeef0123456789abcdeffedcba98;
    run(encrypt(pt), pt, 1'b1, "R10 start during rounds ignored");

    // R9 random round trips, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 40; n++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      pt  = {$urandom, $urandom, $urandom, $urandom};
      expand(key);
      ct = encrypt(pt);
      run(ct, pt, (n % 7) == 3, "R9 random round trip");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule